// File: doc/BRIEF.md
# SMBus Host Register and Status Unit

This block is the byte-wide register front end of an SMBus host controller. Software reaches it through a 4-bit offset port. The port holds a status register, a control register, a command byte, a target address byte, two data bytes, a block data port, a PEC byte, an auxiliary status register and an auxiliary control register. The block tracks whether a transaction is in flight, keeps sticky result flags, and hands each accepted start to a protocol engine. The engine receives a one-cycle request and a latched command code, and returns a done, no-acknowledge or lost-arbitration pulse. Serial bit timing lives in the engine and is not part of this block.

A small state machine sequences each transaction. It has three states. IDLE waits for a start. ISSUE is the single cycle in which the engine request is raised. RUN waits for the engine. The transitions are as follows. IDLE goes to ISSUE on an accepted start. ISSUE goes to RUN on the next cycle, or back to IDLE if the kill bit is set. RUN goes back to IDLE on kill, lost arbitration, no-acknowledge or done, in that order of priority. The busy indication is high in ISSUE and RUN.

The block data port has two modes. In buffered mode, successive accesses walk an internal byte array. Otherwise it behaves as a single byte register.

Top module: `smb_host_regs`

## Requirements
- R1: After reset, every register reads 0x00, `eng_req` is low and `eng_abort` is low.
- R2: Offsets 3 (command), 4 (address), 5 (data0), 6 (data1) and 8 (PEC) read back the last byte written to them. Auxiliary control at offset 13 keeps bits 1:0 and reads zero in bits 7:2.
- R3: A control write (offset 2) with bit 6 set, bit 1 clear, while idle and with no sticky flag set, is accepted. `eng_req` is then high for exactly one cycle, starting after the write edge. `eng_cmd` holds control bits 5:2 and `eng_pec` holds control bit 7. Status bit 0 (busy) reads 1. Control bit 6 always reads 0; the other control bits read back as written.
- R4: A start written while busy issues no request and leaves `eng_cmd` and `eng_pec` unchanged.
- R5: A start is refused while any sticky flag is set. The sticky flags are status bits 7, 4, 3, 2 and 1.
- R6: An `eng_done` pulse in RUN clears busy and sets status bit 1 (completion).
- R7: An `eng_nak` pulse in RUN sets status bit 2 (device error) and bit 1, and clears busy.
- R8: An `eng_lost` pulse in RUN sets status bit 3 (bus error) and clears busy, with bit 1 left clear.
- R9: `eng_abort` follows control bit 1. While that bit is set during a transaction, busy clears on the next edge and status bit 4 (failed) is set. The kill takes priority over any engine pulse in the same cycle.
- R10: Writing status with a 1 in bits 7, 5, 4, 3, 2 or 1 clears those flags. A 0 leaves a flag unchanged, and a new event that occurs on the same edge wins over the clear.
- R11: Status bit 6 (in-use) reads as its current value, and each status read then sets it. Writing 1 to bit 6 clears it.
- R12: With auxiliary control bit 1 set, writes and reads of offset 7 step through a byte array in order, and a read of the control register rewinds the position to zero. With bit 1 clear, offset 7 is a single byte register.
- R13: An `eng_byte` pulse sets status bit 7, an `alert_in` pulse sets status bit 5, and an `eng_crc_err` pulse sets auxiliary status bit 0. Writing 1 to auxiliary status bit 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for read side effects) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| eng_req | output | 1 | One-cycle transaction request to the engine |
| eng_cmd | output | 4 | Command code latched at start |
| eng_pec | output | 1 | PEC enable latched at start |
| eng_abort | output | 1 | Abort level to the engine (control kill bit) |
| eng_done | input | 1 | Engine reports normal completion |
| eng_nak | input | 1 | Engine reports no acknowledge |
| eng_lost | input | 1 | Engine reports lost arbitration |
| eng_byte | input | 1 | Engine reports a byte transferred |
| eng_crc_err | input | 1 | Engine reports a PEC mismatch |
| alert_in | input | 1 | Alert event pulse |

## Verification
The assertions check several properties on every cycle. The request pulse lasts one cycle and is only raised when the previous cycle was idle and free of sticky flags. A set kill bit always drops busy on the next edge. Each engine outcome lands in its matching status flag. The latched command holds steady through a run. Only the bench scenarios can show the software-visible side. That covers the register read-back values, the write-one-to-clear masks, the in-use semaphore sequence, the ordering of bytes through the block buffer and its rewind, and the refusals seen through an unchanged request count.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

    // Register offsets (software-visible map)
    localparam logic [3:0] OFS_STAT = 4'd0;
    localparam logic [3:0] OFS_CTRL = 4'd2;
    localparam logic [3:0] OFS_CMD  = 4'd3;
    localparam logic [3:0] OFS_ADDR = 4'd4;
    localparam logic [3:0] OFS_DAT0 = 4'd5;
    localparam logic [3:0] OFS_DAT1 = 4'd6;
    localparam logic [3:0] OFS_BLK  = 4'd7;
    localparam logic [3:0] OFS_PEC  = 4'd8;
    localparam logic [3:0] OFS_AUXS = 4'd12;
    localparam logic [3:0] OFS_AUXC = 4'd13;

    // Status bit positions
    localparam int SB_BUSY  = 0;
    localparam int SB_INTR  = 1;
    localparam int SB_DEV   = 2;
    localparam int SB_BUS   = 3;
    localparam int SB_FAIL  = 4;
    localparam int SB_ALERT = 5;
    localparam int SB_INUSE = 6;
    localparam int SB_BYTE  = 7;

    // Control bit positions
    localparam int CB_KILL  = 1;
    localparam int CB_CMDLO = 2;
    localparam int CB_START = 6;
    localparam int CB_PEC   = 7;

    // Sticky flags that block a new start
    localparam logic [7:0] STICKY_MASK = 8'b1001_1110;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RUN   = 2'd2
    } host_state_e;

endpackage

// File: rtl/smb_host_fsm.sv
module smb_host_fsm
    import smb_host_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic start_kill,
    input  logic sticky_any,
    input  logic kill_lvl,
    input  logic eng_done,
    input  logic eng_nak,
    input  logic eng_lost,
    output logic busy,
    output logic issue,
    output logic accept,
    output logic ev_done,
    output logic ev_nak,
    output logic ev_lost,
    output logic ev_kill
);

    host_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        ev_done = 1'b0;
        ev_nak  = 1'b0;
        ev_lost = 1'b0;
        ev_kill = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_wr && !start_kill && !sticky_any) begin
                    accept  = 1'b1;
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (kill_lvl) begin
                    ev_kill = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (kill_lvl) begin
                    ev_kill = 1'b1;
                    state_d = ST_IDLE;
                end else if (eng_lost) begin
                    ev_lost = 1'b1;
                    state_d = ST_IDLE;
                end else if (eng_nak) begin
                    ev_nak  = 1'b1;
                    state_d = ST_IDLE;
                end else if (eng_done) begin
                    ev_done = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy  = (state_q != ST_IDLE);
        issue = (state_q == ST_ISSUE);
    end

    p_req_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !issue);

    p_no_req_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !$past(busy));

    p_no_req_with_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !$past(sticky_any));

    p_kill_drops_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kill_lvl) |=> !busy);

endmodule

// File: rtl/smb_status_flags.sv
module smb_status_flags
    import smb_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       ev_done,
    input  logic       ev_nak,
    input  logic       ev_lost,
    input  logic       ev_kill,
    input  logic       set_byte,
    input  logic       set_alert,
    input  logic       sem_rd,
    input  logic       w1c_we,
    input  logic [7:1] w1c_mask,
    output logic [7:0] stat,
    output logic       sticky_any
);

    logic [7:1] flag_q;
    logic [7:1] set_vec;
    logic [7:1] clr_vec;

    always_comb begin
        set_vec           = '0;
        set_vec[SB_BYTE]  = set_byte;
        set_vec[SB_INUSE] = sem_rd;
        set_vec[SB_ALERT] = set_alert;
        set_vec[SB_FAIL]  = ev_kill;
        set_vec[SB_BUS]   = ev_lost;
        set_vec[SB_DEV]   = ev_nak;
        set_vec[SB_INTR]  = ev_done | ev_nak;
        clr_vec           = w1c_we ? w1c_mask : '0;
    end

    for (genvar gi = 1; gi < 8; gi++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q[gi] <= 1'b0;
            else        flag_q[gi] <= set_vec[gi] | (flag_q[gi] & ~clr_vec[gi]);
        end
    end

    always_comb begin
        stat       = {flag_q, busy};
        sticky_any = |(stat & STICKY_MASK);
    end

    p_done_sets_intr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> stat[SB_INTR]);

    p_nak_sets_dev_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nak |=> (stat[SB_DEV] && stat[SB_INTR]));

    p_lost_sets_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_lost |=> stat[SB_BUS]);

    p_kill_sets_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_kill |=> stat[SB_FAIL]);

endmodule

// File: rtl/smb_blk_port.sv
module smb_blk_port #(
    parameter int DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       buf_mode,
    input  logic       we,
    input  logic       re,
    input  logic       idx_clr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);

    logic [7:0] single_q;

    if (DEPTH > 1) begin : g_buf
        localparam int IW = $clog2(DEPTH);
        localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

        logic [7:0]    mem [DEPTH];
        logic [IW-1:0] idx_q;
        logic [IW-1:0] idx_nx;

        always_comb idx_nx = (idx_q == LAST) ? '0 : idx_q + 1'b1;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                idx_q    <= '0;
                single_q <= '0;
            end else if (idx_clr) begin
                idx_q <= '0;
            end else if (we) begin
                if (buf_mode) idx_q    <= idx_nx;
                else          single_q <= wdata;
            end else if (re && buf_mode) begin
                idx_q <= idx_nx;
            end
        end

        always_ff @(posedge clk) begin
            if (we && buf_mode && !idx_clr) mem[idx_q] <= wdata;
        end

        always_comb rdata = buf_mode ? mem[idx_q] : single_q;
    end else begin : g_single
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  single_q <= '0;
            else if (we) single_q <= wdata;
        end
        always_comb rdata = single_q;
    end

endmodule

// File: rtl/smb_host_regfile.sv
module smb_host_regfile
    import smb_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    input  logic       crc_err,
    output logic [7:0] ctrl_q,
    output logic [7:0] cmd_q,
    output logic [7:0] addr_q,
    output logic [7:0] dat0_q,
    output logic [7:0] dat1_q,
    output logic [7:0] pec_q,
    output logic [1:0] auxc_q,
    output logic       auxs_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmd_q  <= '0;
            addr_q <= '0;
            dat0_q <= '0;
            dat1_q <= '0;
            pec_q  <= '0;
            auxc_q <= '0;
        end else if (wr) begin
            unique case (addr)
                OFS_CTRL: ctrl_q <= wdata & ~(8'd1 << CB_START);
                OFS_CMD:  cmd_q  <= wdata;
                OFS_ADDR: addr_q <= wdata;
                OFS_DAT0: dat0_q <= wdata;
                OFS_DAT1: dat1_q <= wdata;
                OFS_PEC:  pec_q  <= wdata;
                OFS_AUXC: auxc_q <= wdata[1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) auxs_q <= 1'b0;
        else        auxs_q <= crc_err | (auxs_q & ~(wr && addr == OFS_AUXS && wdata[0]));
    end

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_host_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    parameter int CMD_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [3:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             eng_req,
    output logic [CMD_W-1:0] eng_cmd,
    output logic             eng_pec,
    output logic             eng_abort,
    input  logic             eng_done,
    input  logic             eng_nak,
    input  logic             eng_lost,
    input  logic             eng_byte,
    input  logic             eng_crc_err,
    input  logic             alert_in
);

    localparam int CMD_HI = CB_CMDLO + CMD_W - 1;

    logic       wr_stat, wr_ctrl, wr_blk, rd_stat, rd_ctrl, rd_blk;
    logic       start_wr, busy, issue, accept, sticky_any;
    logic       ev_done, ev_nak, ev_lost, ev_kill;
    logic [7:0] stat, ctrl_q, cmd_q, addr_q, dat0_q, dat1_q, pec_q, blk_rd;
    logic [1:0] auxc_q;
    logic       auxs_q;

    always_comb begin
        wr_stat  = reg_wr && (reg_addr == OFS_STAT);
        wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
        wr_blk   = reg_wr && (reg_addr == OFS_BLK);
        rd_stat  = reg_rd && (reg_addr == OFS_STAT);
        rd_ctrl  = reg_rd && (reg_addr == OFS_CTRL);
        rd_blk   = reg_rd && (reg_addr == OFS_BLK);
        start_wr = wr_ctrl && reg_wdata[CB_START];
    end

    smb_host_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_wr   (start_wr),
        .start_kill (reg_wdata[CB_KILL]),
        .sticky_any (sticky_any),
        .kill_lvl   (ctrl_q[CB_KILL]),
        .eng_done   (eng_done),
        .eng_nak    (eng_nak),
        .eng_lost   (eng_lost),
        .busy       (busy),
        .issue      (issue),
        .accept     (accept),
        .ev_done    (ev_done),
        .ev_nak     (ev_nak),
        .ev_lost    (ev_lost),
        .ev_kill    (ev_kill)
    );

    smb_status_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .ev_done    (ev_done),
        .ev_nak     (ev_nak),
        .ev_lost    (ev_lost),
        .ev_kill    (ev_kill),
        .set_byte   (eng_byte),
        .set_alert  (alert_in),
        .sem_rd     (rd_stat),
        .w1c_we     (wr_stat),
        .w1c_mask   (reg_wdata[7:1]),
        .stat       (stat),
        .sticky_any (sticky_any)
    );

    smb_host_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .crc_err (eng_crc_err),
        .ctrl_q  (ctrl_q),
        .cmd_q   (cmd_q),
        .addr_q  (addr_q),
        .dat0_q  (dat0_q),
        .dat1_q  (dat1_q),
        .pec_q   (pec_q),
        .auxc_q  (auxc_q),
        .auxs_q  (auxs_q)
    );

    smb_blk_port #(.DEPTH(BUF_DEPTH)) u_blk (
        .clk      (clk),
        .rst_n    (rst_n),
        .buf_mode (auxc_q[1]),
        .we       (wr_blk),
        .re       (rd_blk),
        .idx_clr  (rd_ctrl),
        .wdata    (reg_wdata),
        .rdata    (blk_rd)
    );

    // Command and PEC enable are captured on the accepting write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_cmd <= '0;
            eng_pec <= 1'b0;
        end else if (accept) begin
            eng_cmd <= reg_wdata[CMD_HI:CB_CMDLO];
            eng_pec <= reg_wdata[CB_PEC];
        end
    end

    always_comb begin
        eng_req   = issue;
        eng_abort = ctrl_q[CB_KILL];
        unique case (reg_addr)
            OFS_STAT: reg_rdata = stat;
            OFS_CTRL: reg_rdata = ctrl_q;
            OFS_CMD:  reg_rdata = cmd_q;
            OFS_ADDR: reg_rdata = addr_q;
            OFS_DAT0: reg_rdata = dat0_q;
            OFS_DAT1: reg_rdata = dat1_q;
            OFS_BLK:  reg_rdata = blk_rd;
            OFS_PEC:  reg_rdata = pec_q;
            OFS_AUXS: reg_rdata = {7'd0, auxs_q};
            OFS_AUXC: reg_rdata = {6'd0, auxc_q};
            default:  reg_rdata = 8'd0;
        endcase
    end

    p_cmd_held_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !issue) |-> ($stable(eng_cmd) && $stable(eng_pec)));

    p_busy_bit_matches_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> stat[SB_BUSY]);

endmodule

// File: tb/sim_smb_host_regs.sv
`timescale 1ns/1ps
module sim_smb_host_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       eng_req, eng_pec, eng_abort;
    logic [3:0] eng_cmd;
    logic       eng_done = 0, eng_nak = 0, eng_lost = 0, eng_byte = 0;
    logic       eng_crc_err = 0, alert_in = 0;

    smb_host_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_req(eng_req), .eng_cmd(eng_cmd), .eng_pec(eng_pec),
        .eng_abort(eng_abort), .eng_done(eng_done), .eng_nak(eng_nak),
        .eng_lost(eng_lost), .eng_byte(eng_byte), .eng_crc_err(eng_crc_err),
        .alert_in(alert_in)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [3:0] a;
        logic [7:0] v;
        string      tag;
    } exp_t;

    exp_t  sb_q[$];
    event  smp_ev;
    int    n_vec = 0, n_bad = 0, req_cnt = 0;
    bit    sem = 1'b0;

    always @(negedge clk) if (rst_n && eng_req) req_cnt++;

    // Monitor: pops the expected read and compares with the port
    always @(smp_ev) begin
        exp_t e;
        e = sb_q.pop_front();
        n_vec++;
        if (reg_rdata !== e.v) begin
            n_bad++;
            $display("FAIL %s: offset %0d read %02h expected %02h", e.tag, e.a, reg_rdata, e.v);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 4'd0 && d[6]) sem = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        e.a = a; e.v = exp; e.tag = tag;
        sb_q.push_back(e);
        #1;
        -> smp_ev;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rds(input logic [7:0] flags, input string tag);
        rd(4'd0, flags | (sem ? 8'h40 : 8'h00), tag);
        sem = 1'b1;
    endtask

    task automatic eng_pulse(input int which);
        @(negedge clk);
        case (which)
            0: eng_done = 1'b1;
            1: eng_nak = 1'b1;
            2: eng_lost = 1'b1;
            3: eng_byte = 1'b1;
            4: alert_in = 1'b1;
            default: eng_crc_err = 1'b1;
        endcase
        @(negedge clk);
        {eng_done, eng_nak, eng_lost, eng_byte, alert_in, eng_crc_err} = '0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 eng_req", int'(eng_req), 0);
        chk("R1 eng_abort", int'(eng_abort), 0);
        rds(8'h00, "R1 status");
        rd(4'd2, 8'h00, "R1 control");
        rd(4'd13, 8'h00, "R1 aux control");
        rd(4'd12, 8'h00, "R1 aux status");
        // R2 plain registers
        wr(4'd3, 8'h5A); wr(4'd4, 8'hA4); wr(4'd5, 8'h13);
        wr(4'd6, 8'hE7); wr(4'd8, 8'h3C); wr(4'd13, 8'hFF);
        rd(4'd3, 8'h5A, "R2 command");
        rd(4'd4, 8'hA4, "R2 address");
        rd(4'd5, 8'h13, "R2 data0");
        rd(4'd6, 8'hE7, "R2 data1");
        rd(4'd8, 8'h3C, "R2 pec");
        rd(4'd13, 8'h03, "R2 aux control");
        wr(4'd13, 8'h00);
        // R3 start with PEC, command 0xB
        wr(4'd2, 8'hEC);
        @(negedge clk);
        chk("R3 request count", req_cnt, 1);
        chk("R3 command", int'(eng_cmd), 11);
        chk("R3 pec", int'(eng_pec), 1);
        rds(8'h01, "R3 busy");
        rd(4'd2, 8'hAC, "R3 control readback");
        // R4 start while busy
        wr(4'd2, 8'h4C);
        @(negedge clk);
        chk("R4 request count", req_cnt, 1);
        chk("R4 command held", int'(eng_cmd), 11);
        chk("R4 pec held", int'(eng_pec), 1);
        // R6 done
        eng_pulse(0);
        rds(8'h02, "R6 done");
        // R5 refused with completion flag set
        wr(4'd2, 8'h44);
        @(negedge clk);
        chk("R5 refused", req_cnt, 1);
        rds(8'h02, "R5 status");
        // R10 write zero keeps, write one clears
        wr(4'd0, 8'h00);
        rds(8'h02, "R10 zero write");
        wr(4'd0, 8'h02);
        rds(8'h00, "R10 one write");
        // R7 no acknowledge
        wr(4'd2, 8'h48);
        eng_pulse(1);
        chk("R7 request count", req_cnt, 2);
        rds(8'h06, "R7 nak");
        wr(4'd0, 8'h06);
        // R8 lost arbitration
        wr(4'd2, 8'h40);
        eng_pulse(2);
        rds(8'h08, "R8 lost");
        wr(4'd0, 8'h08);
        // R9 kill
        wr(4'd2, 8'h40);
        wr(4'd2, 8'h02);
        chk("R9 abort level", int'(eng_abort), 1);
        rds(8'h10, "R9 killed");
        wr(4'd2, 8'h00);
        chk("R9 abort released", int'(eng_abort), 0);
        wr(4'd0, 8'h10);
        rds(8'h00, "R9 cleared");
        // R13 byte-done, alert, crc
        eng_pulse(3);
        eng_pulse(4);
        rds(8'hA0, "R13 byte and alert");
        wr(4'd0, 8'h20);
        rds(8'h80, "R10 partial clear");
        wr(4'd2, 8'h40);
        @(negedge clk);
        chk("R5 byte-done blocks start", req_cnt, 4);
        wr(4'd0, 8'h80);
        rds(8'h00, "R10 byte-done cleared");
        eng_pulse(5);
        rd(4'd12, 8'h01, "R13 crc flag");
        wr(4'd12, 8'h01);
        rd(4'd12, 8'h00, "R13 crc cleared");
        // R11 semaphore
        wr(4'd0, 8'h40);
        rd(4'd0, 8'h00, "R11 first read");
        rd(4'd0, 8'h40, "R11 second read");
        sem = 1'b1;
        // R12 block port
        wr(4'd13, 8'h02);
        rd(4'd2, 8'h00, "R12 rewind");
        wr(4'd7, 8'h11); wr(4'd7, 8'h22); wr(4'd7, 8'h33);
        rd(4'd2, 8'h00, "R12 rewind");
        rd(4'd7, 8'h11, "R12 buffer byte 0");
        rd(4'd7, 8'h22, "R12 buffer byte 1");
        rd(4'd7, 8'h33, "R12 buffer byte 2");
        wr(4'd13, 8'h00);
        wr(4'd7, 8'h99);
        rd(4'd7, 8'h99, "R12 single read");
        rd(4'd7, 8'h99, "R12 single reread");
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule